// File: doc/BRIEF.md
# Tiled Surface Address Mapper

This block turns an element coordinate on a two-dimensional surface into the byte address where that element is stored. A surface is either plain row-major ("linear") or cut into 4 KB tiles. The tiles run row-major across the surface, and each tile holds a fixed rectangle of bytes in one of four in-tile layouts. Each request carries the surface base address, the byte pitch of one row, a layout code, the log2 of the element size and a swizzle enable. The block forms the tile number and the in-tile offset. The offset is a pure permutation of coordinate bits, and for two of the layouts bit 6 of the offset can take an extra XOR.

Requests enter on a valid/ready handshake and pass through two register stages. The first stage builds the coordinate permutation and the tile product. The second stage adds the base. A consumer that holds off its ready freezes both stages in place.

Top module: `tiled_addr_map`

## Requirements
- R1: Layout codes on `in_mode`: 0 linear, 1 X, 2 Y, 3 W, 4 Tile4, and codes 5 to 7 act as linear. In linear mode the address is base + y*pitch + (x << element shift), using all base bits, and the swizzle enable has no effect.
- R2: X layout: the tile is 512 bytes by 8 rows, and the in-tile offset bits 11..0 are v2 v1 v0 u8..u0. Here u is the byte column and v is the row, both reduced to the tile. The tiles per row equal pitch/512.
- R3: Y layout: the tile is 128 bytes by 32 rows, and the offset bits 11..0 are u6 u5 u4 v4 v3 v2 v1 v0 u3 u2 u1 u0. The tiles per row equal pitch/128.
- R4: W layout: the tile covers 64 byte columns by 64 rows, and the offset bits 11..0 are u5 u4 u3 v5 v4 v3 v2 u2 v1 u1 v0 u0. The tiles per row equal pitch/128, where the programmed pitch is twice the logical row width.
- R5: Tile4 layout: the tile is 128 bytes by 32 rows, and the offset bits 11..0 are v4 v3 u6 v2 u5 u4 v1 v0 u3 u2 u1 u0. The tiles per row equal pitch/128.
- R6: With swizzle enabled in X layout, offset bit 6 is XORed with offset bits 9 and 10.
- R7: With swizzle enabled in Y layout, offset bit 6 is XORed with offset bit 9. The enable has no effect in W and Tile4 layouts.
- R8: The byte column is x shifted left by `in_elem_shift` (0 to 4, for 1 to 16 bytes). Shift codes 5 to 7 act as 4.
- R9: In the tiled layouts, the address is {base[31:12], 12'b0} + (tile_row*tiles_per_row + tile_col)*4096 + offset, so the low 12 bits of the base are ignored.
- R10: A request accepted on a rising edge appears on `out_valid`/`out_addr` after the second rising edge that follows, provided `out_ready` is high. Results keep the order of their requests.
- R11: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_addr` hold. `in_ready` is low only when both stages are full and `out_ready` is low.
- R12: After reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request accepted when high with in_valid |
| in_base | input | ADDR_W | Surface base address |
| in_pitch | input | PITCH_W | Row pitch in bytes |
| in_mode | input | 3 | Layout code |
| in_elem_shift | input | 3 | log2 of element size in bytes |
| in_swizzle | input | 1 | Bit-6 XOR enable |
| in_x | input | COORD_W | Element column |
| in_y | input | COORD_W | Element row |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_addr | output | ADDR_W | Byte address |

## Verification
A fault in the bit permutation or in the swizzle XOR shows up at once as a wrong `out_addr`, two edges after the request. The vector set therefore chooses coordinates whose bits are unequal across every field that moves. A fault in the tile number shows up as an address that is off by a multiple of 4096, so several vectors sit outside tile 0. A fault in the stage enables appears during a backpressure run: a held address changes, a result is lost or duplicated, or `in_ready` shows the wrong value in the cycle the pipeline fills.

// File: rtl/tamap_pkg.sv
package tamap_pkg;
  typedef enum logic [2:0] {
    MODE_LIN = 3'd0,
    MODE_X   = 3'd1,
    MODE_Y   = 3'd2,
    MODE_W   = 3'd3,
    MODE_T4  = 3'd4
  } tmode_e;

  localparam int TILE_LG   = 12;  // 4 KB tile
  localparam int MAX_SHIFT = 4;   // 16-byte elements
endpackage

// File: rtl/tamap_offset.sv
// In-tile offset: per-layout permutation of byte column / row bits, plus bit-6 XOR.
module tamap_offset
  import tamap_pkg::*;
(
  input  logic [2:0]  mode,
  input  logic [8:0]  u,
  input  logic [5:0]  v,
  input  logic        swz_en,
  output logic [11:0] off
);
  logic [11:0] raw;

  always_comb begin
    case (mode)
      MODE_X:  raw = {v[2:0], u[8:0]};
      MODE_Y:  raw = {u[6:4], v[4:0], u[3:0]};
      MODE_W:  raw = {u[5:3], v[5:2], u[2], v[1], u[1], v[0], u[0]};
      MODE_T4: raw = {v[4:3], u[6], v[2], u[5:4], v[1:0], u[3:0]};
      default: raw = '0;
    endcase
  end

  always_comb begin
    off = raw;
    if (swz_en && mode == MODE_X)      off[6] = raw[6] ^ raw[9] ^ raw[10];
    else if (swz_en && mode == MODE_Y) off[6] = raw[6] ^ raw[9];
  end
endmodule

// File: rtl/tamap_geom.sv
// Tile column, tile row and tiles per surface row for each layout.
module tamap_geom
  import tamap_pkg::*;
#(
  parameter int COORD_W = 14,
  parameter int PITCH_W = 18,
  parameter int U_W     = COORD_W + 4
) (
  input  logic [2:0]         mode,
  input  logic [U_W-1:0]     u,
  input  logic [COORD_W-1:0] y,
  input  logic [PITCH_W-1:0] pitch,
  output logic [U_W-1:0]     tile_col,
  output logic [COORD_W-1:0] tile_row,
  output logic [PITCH_W-1:0] tiles_per_row
);
  always_comb begin
    case (mode)
      MODE_X: begin
        tile_col      = u >> 9;
        tile_row      = y >> 3;
        tiles_per_row = pitch >> 9;
      end
      MODE_Y, MODE_T4: begin
        tile_col      = u >> 7;
        tile_row      = y >> 5;
        tiles_per_row = pitch >> 7;
      end
      MODE_W: begin
        tile_col      = u >> 6;
        tile_row      = y >> 6;
        tiles_per_row = pitch >> 7;
      end
      default: begin
        tile_col      = '0;
        tile_row      = '0;
        tiles_per_row = '0;
      end
    endcase
  end
endmodule

// File: rtl/tiled_addr_map.sv
module tiled_addr_map
  import tamap_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int COORD_W = 14,
  parameter int PITCH_W = 18
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [ADDR_W-1:0]  in_base,
  input  logic [PITCH_W-1:0] in_pitch,
  input  logic [2:0]         in_mode,
  input  logic [2:0]         in_elem_shift,
  input  logic               in_swizzle,
  input  logic [COORD_W-1:0] in_x,
  input  logic [COORD_W-1:0] in_y,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [ADDR_W-1:0]  out_addr
);
  localparam int U_W = COORD_W + MAX_SHIFT;

  logic [2:0]         es_eff;
  logic [U_W-1:0]     u;
  logic               is_tiled;
  logic [11:0]        off;
  logic [U_W-1:0]     tile_col;
  logic [COORD_W-1:0] tile_row;
  logic [PITCH_W-1:0] tiles_per_row;
  logic [ADDR_W-1:0]  tile_num;
  logic [ADDR_W-1:0]  part_d;
  logic [ADDR_W-1:0]  base_d;

  logic               s1_valid;
  logic [ADDR_W-1:0]  s1_part;
  logic [ADDR_W-1:0]  s1_base;
  logic               en1, en2;

  assign es_eff   = (in_elem_shift > 3'(MAX_SHIFT)) ? 3'(MAX_SHIFT) : in_elem_shift;
  assign u        = U_W'(in_x) << es_eff;
  assign is_tiled = (in_mode == MODE_X) || (in_mode == MODE_Y) ||
                    (in_mode == MODE_W) || (in_mode == MODE_T4);

  tamap_offset u_offset (
    .mode   (in_mode),
    .u      (u[8:0]),
    .v      (in_y[5:0]),
    .swz_en (in_swizzle),
    .off    (off)
  );

  tamap_geom #(.COORD_W(COORD_W), .PITCH_W(PITCH_W), .U_W(U_W)) u_geom (
    .mode          (in_mode),
    .u             (u),
    .y             (in_y),
    .pitch         (in_pitch),
    .tile_col      (tile_col),
    .tile_row      (tile_row),
    .tiles_per_row (tiles_per_row)
  );

  assign tile_num = ADDR_W'(tile_row) * ADDR_W'(tiles_per_row) + ADDR_W'(tile_col);

  always_comb begin
    if (is_tiled) begin
      part_d = (tile_num << TILE_LG) | ADDR_W'(off);
      base_d = {in_base[ADDR_W-1:TILE_LG], {TILE_LG{1'b0}}};
    end else begin
      part_d = ADDR_W'(in_y) * ADDR_W'(in_pitch) + ADDR_W'(u);
      base_d = in_base;
    end
  end

  // Stage enables: a stage loads when it is empty or its content moves on.
  assign en2      = !out_valid || out_ready;
  assign en1      = !s1_valid || en2;
  assign in_ready = en1;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
    end else if (en1) begin
      s1_valid <= in_valid;
    end
    if (en1) begin
      s1_part <= part_d;
      s1_base <= base_d;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
    end else if (en2) begin
      out_valid <= s1_valid;
    end
    if (en2) begin
      out_addr <= s1_base + s1_part;
    end
  end
endmodule

// File: rtl/tiled_addr_map_chk.sv
module tiled_addr_map_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [ADDR_W-1:0] out_addr,
  input logic              s1_valid
);
  p_hold_valid_r11: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> out_valid);

  p_hold_addr_r11: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> $stable(out_addr));

  p_ready_low_r11: assert property (@(posedge clk) disable iff (rst)
    !in_ready |-> (out_valid && !out_ready));

  p_out_origin_r10: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !$past(out_valid)) |-> $past(s1_valid));

  p_reset_empty_r12: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !out_valid);

  p_no_spurious_r10: assert property (@(posedge clk) disable iff (rst)
    (!s1_valid && !out_valid && !in_valid) |=> !out_valid);
endmodule

bind tiled_addr_map tiled_addr_map_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_addr  (out_addr),
  .s1_valid  (s1_valid)
);

// File: tb/tiled_addr_map_bench.sv
module tiled_addr_map_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 32, COORD_W = 14, PITCH_W = 18;
  localparam int NV = 13;

  typedef struct packed {
    logic [31:0] base;
    logic [17:0] pitch;
    logic [2:0]  mode;
    logic [2:0]  es;
    logic        swz;
    logic [13:0] x;
    logic [13:0] y;
    logic [31:0] exp;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{32'h100,   18'h200,  3'd0, 3'd2, 1'b1, 14'd5,   14'd3,  32'h714},   // R1 linear, swizzle ignored
    '{32'h10000, 18'h1000, 3'd1, 3'd2, 1'b0, 14'd130, 14'd11, 32'h19608}, // R2 X layout, R8 4-byte
    '{32'h10000, 18'h1000, 3'd1, 3'd2, 1'b1, 14'd130, 14'd9,  32'h19248}, // R6 X swizzle
    '{32'h10000, 18'h400,  3'd2, 3'd0, 1'b0, 14'd149, 14'd39, 32'h19275}, // R3 Y layout
    '{32'h10000, 18'h400,  3'd2, 3'd0, 1'b1, 14'd149, 14'd39, 32'h19235}, // R7 Y swizzle
    '{32'h10000, 18'h400,  3'd2, 3'd4, 1'b0, 14'd5,   14'd2,  32'h10A20}, // R8 16-byte Y
    '{32'h10000, 18'h400,  3'd3, 3'd0, 1'b1, 14'd75,  14'd71, 32'h1922F}, // R4 W layout, R7 ignored
    '{32'h10000, 18'h400,  3'd4, 3'd0, 1'b1, 14'd90,  14'd27, 32'h10E7A}, // R5 Tile4, R7 ignored
    '{32'h10000, 18'h1000, 3'd1, 3'd1, 1'b0, 14'd300, 14'd0,  32'h11058}, // R2 second tile, 2-byte
    '{32'h2000,  18'h100,  3'd0, 3'd4, 1'b0, 14'd2,   14'd1,  32'h2120},  // R1 linear 16-byte
    '{32'h10ABC, 18'h400,  3'd2, 3'd0, 1'b0, 14'd0,   14'd0,  32'h10000}, // R9 base low bits dropped
    '{32'h100,   18'h40,   3'd7, 3'd0, 1'b0, 14'd1,   14'd1,  32'h141},   // R1 unused code acts linear
    '{32'h10000, 18'h400,  3'd2, 3'd7, 1'b0, 14'd5,   14'd2,  32'h10A20}  // R8 shift code 7 acts as 4
  };

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               in_valid = 1'b0;
  logic               in_ready;
  logic [ADDR_W-1:0]  in_base = '0;
  logic [PITCH_W-1:0] in_pitch = '0;
  logic [2:0]         in_mode = '0;
  logic [2:0]         in_elem_shift = '0;
  logic               in_swizzle = 1'b0;
  logic [COORD_W-1:0] in_x = '0;
  logic [COORD_W-1:0] in_y = '0;
  logic               out_valid;
  logic               out_ready = 1'b1;
  logic [ADDR_W-1:0]  out_addr;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tiled_addr_map #(.ADDR_W(ADDR_W), .COORD_W(COORD_W), .PITCH_W(PITCH_W)) u_tiled_addr_map (
    .clk, .rst, .in_valid, .in_ready, .in_base, .in_pitch, .in_mode,
    .in_elem_shift, .in_swizzle, .in_x, .in_y, .out_valid, .out_ready, .out_addr
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic load(input vec_t v);
    in_base = v.base; in_pitch = v.pitch; in_mode = v.mode;
    in_elem_shift = v.es; in_swizzle = v.swz; in_x = v.x; in_y = v.y;
    in_valid = 1'b1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=0", 1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R12 out_valid after reset", 32'(out_valid), 32'd0);
    check("R12 in_ready after reset", 32'(in_ready), 32'd1);

    // Table walk: one request at a time, output taken at once.
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      load(VECS[i]);
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      check($sformatf("R10 not early, vector %0d", i), 32'(out_valid), 32'd0);
      @(negedge clk);
      check($sformatf("R10 valid, vector %0d", i), 32'(out_valid), 32'd1);
      check($sformatf("R1-R9 address, vector %0d", i), out_addr, VECS[i].exp);
    end

    // Backpressure: fill both stages, hold, then drain in order (R11, R10).
    @(negedge clk);
    out_ready = 1'b0;
    load(VECS[3]);
    @(negedge clk);
    load(VECS[6]);
    @(negedge clk);
    load(VECS[7]);
    check("R11 in_ready low when full", 32'(in_ready), 32'd0);
    check("R11 first result presented", out_addr, VECS[3].exp);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R11 valid held", 32'(out_valid), 32'd1);
      check("R11 address held", out_addr, VECS[3].exp);
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R10 order second", out_addr, VECS[6].exp);
    @(negedge clk);
    check("R10 order third", out_addr, VECS[7].exp);
    check("R10 third valid", 32'(out_valid), 32'd1);
    @(negedge clk);
    check("R10 drained", 32'(out_valid), 32'd0);

    // Back-to-back stream at full rate (R10).
    @(negedge clk);
    load(VECS[1]);
    @(negedge clk);
    load(VECS[4]);
    @(negedge clk);
    in_valid = 1'b0;
    check("R10 stream first", out_addr, VECS[1].exp);
    @(negedge clk);
    check("R10 stream second", out_addr, VECS[4].exp);

    // Reset mid-flight empties the pipeline (R12).
    load(VECS[0]);
    @(negedge clk);
    in_valid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R12 flushed by reset", 32'(out_valid), 32'd0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule